// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a master for the two-wire PHY management bus. It divides the system clock down to a management clock (MDC). It serialises a single frame onto the data line and, on reads, takes the PHY's reply off the same line. Frames are built in either of two framings: the direct clause 22 form, or the indirect clause 45 form, in which an MMD device is addressed. A mode bit chooses the framing. The data line is brought out as an output value, an output enable and an input value, so that a pad cell outside the block can form the tri-state wire.

A host drives a small register port with four words: clock/mode, command, write data and read data. Writing the command word launches exactly one frame. Software polls the pending flags to see when the frame is over. A complete clause 45 access takes two frames: an address frame that loads the MMD register address from the write-data word, followed by a read or write frame to the same port and device.

The frame engine is a state machine with the states IDLE, PREAMBLE, HEADER, TURN and DATA.
- A command accepted in IDLE moves it to PREAMBLE when the preamble is enabled, and to HEADER otherwise.
- On the falling MDC edge that ends the last bit of a segment, PREAMBLE moves to HEADER after 32 bits, HEADER moves to TURN after 14 bits, TURN moves to DATA after 2 bits, and DATA returns to IDLE after 16 bits.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, the data-line enable is low, both pending flags and the valid flag read 0, and the clock/mode word reads a divider of 4 with both mode bits clear.
- R2: The host word map is as follows.
  - Address 0 is the clock/mode word: [7:0] holds the half-period N, [8] selects clause 45 when 1, and [9] enables the preamble. Writing [8]=1 always sets [9].
  - Address 1 is the command word: [1:0] is the operation, [6:2] is the port address and [11:7] is the register or device address.
  - Address 2 is the write-data word: [15:0] is the value and [16] is the write pending flag.
  - Address 3 is the read-data word: [15:0] is the data, [16] is the valid flag and [17] is the read pending flag.
  - Each MDC half-period lasts N system clocks, and N=0 acts as 1.
- R3: A clause 22 frame is sent MSB first in this order: 32 ones when the preamble is on, start code 01, then the wire opcode, the 5-bit port, the 5-bit register address, turnaround 10 and 16 data bits from the write-data word. The wire opcode is 10 (read) when operation bit 0 is 1, and 01 (write) otherwise.
- R4: A clause 45 frame uses start code 00, and its wire opcode equals the operation. Operation 0 (address) and operation 1 (write) send the write-data word as the 16 data bits. Operations 2 and 3 are reads. The preamble is always present.
- R5: While a frame runs, the data-line output changes only at the clock edge where MDC falls. The first bit is presented when the command is accepted.
- R6: On reads, the enable is low from the first turnaround bit to the end of the frame. The data bits are sampled on rising MDC edges, MSB first, into read-data [15:0].
- R7: The valid flag is cleared when a read starts. At the end of the read it is set to 1 only if the PHY drove the second turnaround bit low.
- R8: The read pending flag is set for reads, and the write pending flag is set for writes and address operations. The flag is set at the edge that accepts the command and clears at the MDC fall that ends the last data bit. MDC is then low and the enable is low.
- R9: While a frame is pending, host writes to the command, write-data and clock/mode words are ignored. No second frame starts, and the stored values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Host write strobe |
| csr_addr | input | 2 | Host word address |
| csr_wdata | input | 16 | Host write value |
| csr_rdata | output | 32 | Host read value for csr_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data-line output value |
| mdio_oe | output | 1 | Data-line drive enable |
| mdio_i | input | 1 | Data-line input value |

## Verification
The command is accepted at the write edge, so a pending flag is due at the next falling system clock. With a half-period of N and a frame of L bits, MDC rises for bit k at N·(2k+1) clocks after acceptance, and pending clears 2·N·L clocks after acceptance. The bench captures the line at every MDC rise and counts MDC-high clocks at falling system edges, expecting exactly N·L of them. It polls the flags only at falling system edges and compares the frame and read-back words only after pending has cleared. Its PHY model updates the data line just after each MDC rise, so each value is stable at the following rise when the block samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_BITS = 32;
    localparam int HDR_BITS = 14;
    localparam int TA_BITS  = 2;
    localparam int DAT_BITS = 16;
    localparam int ADR_W    = 5;
    localparam int SHIFT_W  = HDR_BITS + TA_BITS + DAT_BITS;
    localparam int SEG_W    = $clog2(PRE_BITS);

    localparam logic [1:0] W_CLK  = 2'd0;
    localparam logic [1:0] W_CMD  = 2'd1;
    localparam logic [1:0] W_WDAT = 2'd2;
    localparam logic [1:0] W_RDAT = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREAMBLE,
        S_HEADER,
        S_TURN,
        S_DATA
    } frame_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             wrap;

    always_comb begin
        lim      = (half == '0) ? DIV_W'(1) : half;
        wrap     = run && (cnt >= lim - DIV_W'(1));
        rise_stb = wrap && !mdc;
        fall_stb = wrap && mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // R2
    mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rise_stb && !fall_stb) |=> $stable(mdc))
        else $error("mdc moved without a strobe");
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                clause45,
    input  logic                pre_en,
    input  logic [1:0]          op,
    input  logic [ADR_W-1:0]    port,
    input  logic [ADR_W-1:0]    regad,
    input  logic [DAT_BITS-1:0] wdata,
    input  logic                rise_stb,
    input  logic                fall_stb,
    input  logic                mdio_i,
    output logic                busy,
    output logic                rd_kind,
    output logic                done,
    output logic                rd_ok,
    output logic [DAT_BITS-1:0] rd_data,
    output logic                mdio_o,
    output logic                mdio_oe
);
    frame_state_e         state;
    frame_state_e         nxt;
    logic [SEG_W-1:0]     cnt;
    logic [SHIFT_W-1:0]   sreg;
    logic [SHIFT_W-1:0]   load;
    logic [DAT_BITS-1:0]  shin;
    logic                 rd_q;
    logic                 ta_ok_q;
    logic                 seg_last;
    logic [1:0]           st_code;
    logic [1:0]           op_wire;

    // frame image built from the command at acceptance
    always_comb begin
        rd_kind = clause45 ? op[1] : op[0];
        st_code = clause45 ? 2'b00 : 2'b01;
        op_wire = clause45 ? op : (op[0] ? 2'b10 : 2'b01);
        load    = {st_code, op_wire, port, regad,
                   rd_kind ? 2'b11 : 2'b10,
                   rd_kind ? {DAT_BITS{1'b1}} : wdata};
    end

    // segment end and successor
    always_comb begin
        seg_last = 1'b0;
        nxt      = S_IDLE;
        unique case (state)
            S_PREAMBLE: begin seg_last = (cnt == SEG_W'(PRE_BITS-1)); nxt = S_HEADER; end
            S_HEADER:   begin seg_last = (cnt == SEG_W'(HDR_BITS-1)); nxt = S_TURN;   end
            S_TURN:     begin seg_last = (cnt == SEG_W'(TA_BITS-1));  nxt = S_DATA;   end
            S_DATA:     begin seg_last = (cnt == SEG_W'(DAT_BITS-1)); nxt = S_IDLE;   end
            default:    begin seg_last = 1'b0; nxt = S_IDLE; end
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            sreg    <= '0;
            shin    <= '0;
            rd_q    <= 1'b0;
            ta_ok_q <= 1'b0;
        end else if (state == S_IDLE) begin
            if (start) begin
                state   <= pre_en ? S_PREAMBLE : S_HEADER;
                cnt     <= '0;
                sreg    <= load;
                rd_q    <= rd_kind;
                ta_ok_q <= 1'b0;
            end
        end else begin
            if (rise_stb) begin
                if (state == S_TURN && cnt == SEG_W'(TA_BITS-1))
                    ta_ok_q <= ~mdio_i;
                if (state == S_DATA)
                    shin <= {shin[DAT_BITS-2:0], mdio_i};
            end
            if (fall_stb) begin
                if (state != S_PREAMBLE)
                    sreg <= sreg << 1;
                if (seg_last) begin
                    cnt   <= '0;
                    state <= nxt;
                end else begin
                    cnt <= cnt + SEG_W'(1);
                end
            end
        end
    end

    // output process
    always_comb begin
        busy    = (state != S_IDLE);
        done    = fall_stb && (state == S_DATA) && seg_last;
        rd_ok   = rd_q && ta_ok_q;
        rd_data = shin;
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        unique case (state)
            S_IDLE:     begin mdio_o = 1'b1; mdio_oe = 1'b0; end
            S_PREAMBLE: begin mdio_o = 1'b1; mdio_oe = 1'b1; end
            S_HEADER:   begin mdio_o = sreg[SHIFT_W-1]; mdio_oe = 1'b1; end
            S_TURN,
            S_DATA:     begin mdio_o = sreg[SHIFT_W-1]; mdio_oe = ~rd_q; end
            default:    begin mdio_o = 1'b1; mdio_oe = 1'b0; end
        endcase
    end

    // R5
    mdio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && !fall_stb) |=> $stable(mdio_o))
        else $error("data line moved away from an MDC fall");
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int               DIV_W     = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(4)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr,
    input  logic [1:0]  csr_addr,
    input  logic [15:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [DIV_W-1:0]    div_q;
    logic                mode_q;
    logic                pre_q;
    logic [DAT_BITS-1:0] wdat_q;
    logic [DAT_BITS-1:0] rdat_q;
    logic                rvalid_q;
    logic                wpend_q;
    logic                rpend_q;

    logic                busy;
    logic                rd_kind;
    logic                done;
    logic                rd_ok;
    logic [DAT_BITS-1:0] rd_data;
    logic                rise_stb;
    logic                fall_stb;
    logic                start;
    logic                host_ok;

    assign host_ok = csr_wr && !busy;
    assign start   = host_ok && (csr_addr == W_CMD);

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half     (div_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .clause45 (mode_q),
        .pre_en   (pre_q),
        .op       (csr_wdata[1:0]),
        .port     (csr_wdata[6:2]),
        .regad    (csr_wdata[11:7]),
        .wdata    (wdat_q),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .rd_kind  (rd_kind),
        .done     (done),
        .rd_ok    (rd_ok),
        .rd_data  (rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= DIV_RESET;
            mode_q   <= 1'b0;
            pre_q    <= 1'b0;
            wdat_q   <= '0;
            rdat_q   <= '0;
            rvalid_q <= 1'b0;
            wpend_q  <= 1'b0;
            rpend_q  <= 1'b0;
        end else begin
            if (host_ok && csr_addr == W_CLK) begin
                div_q  <= csr_wdata[DIV_W-1:0];
                mode_q <= csr_wdata[8];
                pre_q  <= csr_wdata[9] | csr_wdata[8];
            end
            if (host_ok && csr_addr == W_WDAT)
                wdat_q <= csr_wdata;
            if (start) begin
                wpend_q <= ~rd_kind;
                rpend_q <= rd_kind;
                if (rd_kind)
                    rvalid_q <= 1'b0;
            end
            if (done) begin
                wpend_q <= 1'b0;
                rpend_q <= 1'b0;
                if (rpend_q) begin
                    rdat_q   <= rd_data;
                    rvalid_q <= rd_ok;
                end
            end
        end
    end

    always_comb begin
        csr_rdata = '0;
        unique case (csr_addr)
            W_CLK:   csr_rdata = {22'd0, pre_q, mode_q, 8'(div_q)};
            W_CMD:   csr_rdata = '0;
            W_WDAT:  csr_rdata = {15'd0, wpend_q, wdat_q};
            W_RDAT:  csr_rdata = {14'd0, rpend_q, rvalid_q, rdat_q};
            default: csr_rdata = '0;
        endcase
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe))
        else $error("idle bus not quiet");

    // R8
    pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wpend_q || rpend_q) == busy) && !(wpend_q && rpend_q))
        else $error("pending flags disagree with engine");

    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid_q) |-> $past(done))
        else $error("valid set outside frame end");
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [15:0] csr_wdata = 16'd0;
    logic [31:0] csr_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    mdio_master i_mdio_master (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // PHY model state, set by the stimulus
    int          base = 0;
    int          phy_pre = 0;
    bit          phy_read = 0;
    bit          phy_present = 1;
    logic [15:0] phy_val = 16'h0;

    // capture, driven only by the MDC monitor
    int   cap_n = 0;
    logic cap_o  [0:63];
    logic cap_oe [0:63];

    function automatic logic phy_bit(int i);
        if (!phy_read || !phy_present) return 1'b1;
        if (i == phy_pre + 15) return 1'b0;
        if (i >= phy_pre + 16 && i < phy_pre + 32) return phy_val[15 - (i - phy_pre - 16)];
        return 1'b1;
    endfunction

    assign mdio_i = phy_bit(cap_n - base);

    always @(posedge mdc) begin
        if (cap_n - base >= 0 && cap_n - base < 64) begin
            cap_o[cap_n - base]  = mdio_o;
            cap_oe[cap_n - base] = mdio_oe;
        end
        cap_n = cap_n + 1;
    end

    // system-clock monitor: MDC-high clocks and line changes off the MDC fall
    int   hi_cycles = 0;
    int   viol = 0;
    logic p_o = 1'b1, p_oe = 1'b0, p_mdc = 1'b0;
    always @(negedge clk) begin
        if (mdc) hi_cycles = hi_cycles + 1;
        if (mdio_o !== p_o && p_oe && mdio_oe && !(p_mdc && !mdc)) viol = viol + 1;
        p_o = mdio_o; p_oe = mdio_oe; p_mdc = mdc;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic run_txn(input int div, input bit c45, input bit pre, input logic [1:0] op,
                           input logic [4:0] port, input logic [4:0] rg, input logic [15:0] wd,
                           input bit present, input logic [15:0] pval, input bit poke);
        logic [31:0] rd;
        logic [63:0] exp_o, exp_oe;
        int L, idx, h0, v0, deff, bad_o, bad_oe, waited;
        logic [13:0] hdr;
        logic [1:0]  opw;
        bit pre_on, isrd;
        pre_on = pre | c45;
        isrd   = c45 ? op[1] : op[0];
        deff   = (div == 0) ? 1 : div;
        csr_write(2'd0, {6'd0, pre, c45, 8'(div)});
        csr_write(2'd2, wd);
        phy_pre = pre_on ? 32 : 0;
        phy_read = isrd; phy_present = present; phy_val = pval;
        base = cap_n; h0 = hi_cycles; v0 = viol;
        csr_write(2'd1, {4'd0, rg, port, op});
        csr_read(isrd ? 2'd3 : 2'd2, rd);
        check(rd[isrd ? 17 : 16] == 1'b1, "R8 pending set", rd, 1);
        if (isrd) check(rd[16] == 1'b0, "R7 valid cleared at read start", rd[16], 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            csr_write(2'd1, 16'h0F3D);
            csr_write(2'd2, 16'hBEEF);
            csr_write(2'd0, 16'h0101);
        end
        waited = 0;
        do begin
            @(negedge clk);
            csr_read(2'd2, rd);
            waited++;
            if (rd[16] == 1'b0) begin
                csr_read(2'd3, rd);
                if (rd[17] == 1'b0) break;
            end
        end while (waited < 20000);
        L = phy_pre + 32;
        // expected frame
        exp_o = '0; exp_oe = '0; idx = 0;
        if (pre_on) for (int k = 0; k < 32; k++) begin exp_o[idx] = 1; exp_oe[idx] = 1; idx++; end
        opw = c45 ? op : (op[0] ? 2'b10 : 2'b01);
        hdr = {c45 ? 2'b00 : 2'b01, opw, port, rg};
        for (int k = 13; k >= 0; k--) begin exp_o[idx] = hdr[k]; exp_oe[idx] = 1; idx++; end
        exp_o[idx] = 1; exp_oe[idx] = !isrd; idx++;
        exp_o[idx] = 0; exp_oe[idx] = !isrd; idx++;
        for (int k = 15; k >= 0; k--) begin exp_o[idx] = wd[k]; exp_oe[idx] = !isrd; idx++; end
        bad_o = 0; bad_oe = 0;
        for (int k = 0; k < L; k++) begin
            if (cap_oe[k] !== exp_oe[k]) bad_oe++;
            if (exp_oe[k] && cap_o[k] !== exp_o[k]) bad_o++;
        end
        check(cap_n - base == L, c45 ? "R4 frame length" : "R3 frame length", cap_n - base, L);
        check(bad_o == 0, c45 ? "R4 frame bits" : "R3 frame bits", bad_o, 0);
        check(bad_oe == 0, "R6 drive enable pattern", bad_oe, 0);
        check(hi_cycles - h0 == deff * L, "R2 MDC high clocks", hi_cycles - h0, deff * L);
        check(viol - v0 == 0, "R5 line change off MDC fall", viol - v0, 0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 bus quiet at end", {mdc, mdio_oe}, 0);
        if (isrd) begin
            csr_read(2'd3, rd);
            check(rd[15:0] == (present ? pval : 16'hFFFF), "R6 read data", rd[15:0], present ? pval : 16'hFFFF);
            check(rd[16] == present, "R7 valid flag", rd[16], present);
        end
        if (poke) begin
            repeat (60) @(negedge clk);
            check(cap_n - base == L, "R9 no second frame", cap_n - base, L);
            csr_read(2'd2, rd);
            check(rd[15:0] == wd, "R9 write data kept", rd[15:0], wd);
            csr_read(2'd0, rd);
            check(rd[9:0] == {pre_on, c45, 8'(div)}, "R9 clock word kept", rd[9:0], {pre_on, c45, 8'(div)});
        end
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        csr_read(2'd3, rd);
        check(rd[17:16] == 2'b00, "R1 read flags at reset", rd[17:16], 0);
        csr_read(2'd2, rd);
        check(rd[16] == 1'b0, "R1 write pending at reset", rd[16], 0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 bus quiet at reset", {mdc, mdio_oe}, 0);
        csr_read(2'd0, rd);
        check(rd[9:0] == 10'h004, "R1 clock word at reset", rd[9:0], 10'h004);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        csr_write(2'd0, 16'h0103);
        csr_read(2'd0, rd);
        check(rd[9:0] == 10'h303, "R2 clause 45 forces preamble", rd[9:0], 10'h303);
        csr_write(2'd0, 16'h0005);
        csr_read(2'd0, rd);
        check(rd[9:0] == 10'h005, "R2 clause 22 preamble off", rd[9:0], 10'h005);

        for (int dv = 1; dv <= 3; dv++)
            for (int m = 0; m < 2; m++)
                for (int o = 0; o < 4; o++) begin
                    logic [15:0] w;
                    w = 16'hA5C3 ^ (16'(o) * 16'h1111) ^ (16'(dv) << 9);
                    run_txn(dv, m[0], o[0], o[1:0], 5'((dv * 7 + o * 3 + m) & 31),
                            5'((dv * 5 + o * 11 + m * 17) & 31), w,
                            !(o == 3 && dv == 2), ~w, 1'b0);
                end
        // divider value 0 behaves as 1
        run_txn(0, 1'b0, 1'b0, 2'd1, 5'h1F, 5'h00, 16'h8001, 1'b1, 16'h0, 1'b0);
        // host writes during a frame are ignored
        run_txn(3, 1'b1, 1'b1, 2'd1, 5'h0A, 5'h15, 16'h3C5A, 1'b1, 16'h0, 1'b1);
        run_txn(2, 1'b0, 1'b1, 2'd1, 5'h11, 5'h0E, 16'h0000, 1'b1, 16'hF00D, 1'b1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
            $finish;
        end
    end
endmodule